// File: doc/BRIEF.md
# Real-time clock prescaler with digital trim

This block divides a slow reference tick, normally 32.768 kHz, into a one-second strobe for a real-time clock. It can also shorten or lengthen selected seconds by a programmable number of slow-clock pulses. Over a 20 s or 60 s window this cancels a known frequency error of the crystal. Converting a wanted ppb error into a code is left to software. The block takes the code and applies it once per correction window.

One 8-bit trim word holds all the settings. Bit 7 picks the window: 1 means every 60 s and 0 means every 20 s. Bit 6 picks the direction. Bits 5:0 hold a magnitude code, and a code of 0 turns correction off. A write goes into a pending copy and raises a busy flag. The pending copy becomes the active setting at the next one-second boundary, and busy clears on that same boundary.

A compare-divider mode replaces the fixed division with a programmed count, for slow clocks that do not run at 32.768 kHz. Trim is ignored in that mode.

Top module: `rtc_trim_unit`

## Requirements
- R1: After reset, `sec_pulse_o` and `trim_busy_o` are 0 and the active trim is off, so with the tick present on every clock the strobe period is DIV clocks even while seconds read 0x00.
- R2: An active magnitude code of 0 (bits 5:0) gives a period of DIV at every seconds value and in either direction.
- R3: With bit 6 clear and code c ≥ 1, a correction second lasts DIV − 2·(c − 1) ticks, because the pulses are added to the count. A code of 1 leaves the period at DIV, and a code of 63 removes 124 ticks.
- R4: With bit 6 set and code c ≥ 1, a correction second lasts DIV + 2·(((~c) & 63) + 1) ticks. Code 0x3F adds 2 ticks, code 0x3E adds 4 and code 0x01 adds 126.
- R5: With bit 7 clear, the correction seconds are those where `sec_bcd_i` reads 0x00, 0x20 or 0x40. Every other seconds value, such as 0x10, gets the nominal period.
- R6: With bit 7 set, only seconds value 0x00 is corrected, and 0x20 or 0x40 gets the nominal period.
- R7: A write raises `trim_busy_o` on the next clock. The second already in progress keeps the old setting. At the next strobe the new setting becomes active and busy falls in the same cycle as the strobe.
- R8: When `cmp_mode_i` is 1, the period is `cmp_val_i` + 1 ticks, and the trim word has no effect.
- R9: The prescaler advances only on clocks where `tick_i` is 1. The strobe is one clock wide and follows the final tick of a second by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock enable per slow-clock period |
| sec_bcd_i | input | 8 | Current seconds value from the counter, BCD |
| trim_wr_i | input | 1 | Write strobe for the trim word |
| trim_data_i | input | 8 | Trim word: [7] 60 s window, [6] subtract, [5:0] code |
| cmp_mode_i | input | 1 | Selects the compare-divider mode |
| cmp_val_i | input | CMP_W | Compare-divider count minus one |
| sec_pulse_o | output | 1 | One-second strobe |
| trim_busy_o | output | 1 | Trim write pending, not yet active |

## Verification
A wrong decode of the magnitude, direction or window shows up as a wrong strobe spacing, but only in a correction second. The error is therefore visible one full second after the setting becomes active, and only while the seconds input holds a matching value. A stuck or misplaced busy flag, or a setting latched at the wrong moment, makes the second in progress during a write take the new length too early or too late. It can also leave busy high past the next strobe, which is seen at the first strobe after the write. A prescaler that ignores the tick enable stretches nothing during a tick gap, so the period comes out short by exactly the gap length.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   typedef struct packed {
      logic       long_win;   // 1: correct every 60 s, 0: every 20 s
      logic       subtract;   // 1: lengthen the second, 0: shorten it
      logic [5:0] code;       // magnitude code, 0 = off
   } trim_word_t;

   localparam int unsigned CODE_W  = 6;
   localparam int unsigned PULSE_W = 8;     // up to 126 pulses

   // Pulses removed or added for a given word (always even).
   function automatic logic [PULSE_W-1:0] trim_pulses(input trim_word_t w);
      logic [CODE_W:0] steps;
      if (w.code == '0)
         steps = '0;
      else if (w.subtract)
         steps = {1'b0, ~w.code} + 7'd1;
      else
         steps = {1'b0, w.code} - 7'd1;
      return {steps, 1'b0};
   endfunction

endpackage

// File: rtl/trim_word_reg.sv
module trim_word_reg
   import rtc_trim_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [7:0] data_i,
   input  logic       boundary_i,
   output trim_word_t active_o,
   output logic       busy_o
);

   trim_word_t pending_q;
   trim_word_t active_q;
   logic       busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= '0;
         active_q  <= '0;
         busy_q    <= 1'b0;
      end else begin
         if (boundary_i && busy_q) begin
            active_q <= pending_q;
            busy_q   <= 1'b0;
         end
         if (wr_i) begin
            pending_q <= trim_word_t'(data_i);
            busy_q    <= 1'b1;
         end
      end
   end

   assign active_o = active_q;
   assign busy_o   = busy_q;

endmodule

// File: rtl/trim_limit_calc.sv
module trim_limit_calc
   import rtc_trim_pkg::*;
#(
   parameter int unsigned DIV         = 32768,
   parameter int unsigned CMP_W       = 22,
   parameter int unsigned CNT_W       = 24,
   parameter bit          BCD_SECONDS = 1'b1
)(
   input  trim_word_t       active_i,
   input  logic [7:0]       sec_i,
   input  logic             cmp_mode_i,
   input  logic [CMP_W-1:0] cmp_val_i,
   output logic [CNT_W-1:0] limit_o
);

   localparam logic [7:0] SEC_A = BCD_SECONDS ? 8'h20 : 8'd20;
   localparam logic [7:0] SEC_B = BCD_SECONDS ? 8'h40 : 8'd40;
   localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(DIV);

   logic                corr_sec;
   logic                window_hit;
   logic [PULSE_W-1:0]  pulses;
   logic [CNT_W-1:0]    pulses_ext;
   logic [CNT_W-1:0]    trimmed;

   generate
      if (BCD_SECONDS) begin : g_bcd
         assign window_hit = (sec_i == 8'h00) ||
                             (!active_i.long_win && ((sec_i == SEC_A) || (sec_i == SEC_B)));
      end else begin : g_bin
         assign window_hit = (sec_i == 8'd0) ||
                             (!active_i.long_win && ((sec_i == SEC_A) || (sec_i == SEC_B)));
      end
   endgenerate

   assign corr_sec   = (active_i.code != '0) && window_hit;
   assign pulses     = trim_pulses(active_i);
   assign pulses_ext = CNT_W'(pulses);
   assign trimmed    = active_i.subtract ? (NOMINAL + pulses_ext) : (NOMINAL - pulses_ext);

   always_comb begin
      if (cmp_mode_i)
         limit_o = CNT_W'(cmp_val_i) + CNT_W'(1);
      else if (corr_sec)
         limit_o = trimmed;
      else
         limit_o = NOMINAL;
   end

endmodule

// File: rtl/presc_counter.sv
module presc_counter #(
   parameter int unsigned CNT_W     = 24,
   parameter bit          PULSE_REG = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             edge_o,
   output logic             pulse_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             last;

   // >= keeps the count bounded if the limit drops below it
   assign last   = (cnt_q + CNT_W'(1)) >= limit_i;
   assign edge_o = tick_i && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
   end

   generate
      if (PULSE_REG) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse_q <= 1'b0;
            else        pulse_q <= edge_o;
         end
         assign pulse_o = pulse_q;
      end else begin : g_comb
         assign pulse_o = edge_o;
      end
   endgenerate

   assign cnt_o = cnt_q;

endmodule

// File: rtl/rtc_trim_unit.sv
module rtc_trim_unit
   import rtc_trim_pkg::*;
#(
   parameter int unsigned DIV         = 32768,
   parameter int unsigned CMP_W       = 22,
   parameter bit          BCD_SECONDS = 1'b1,
   parameter bit          PULSE_REG   = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [7:0]       sec_bcd_i,
   input  logic             trim_wr_i,
   input  logic [7:0]       trim_data_i,
   input  logic             cmp_mode_i,
   input  logic [CMP_W-1:0] cmp_val_i,
   output logic             sec_pulse_o,
   output logic             trim_busy_o
);

   localparam int unsigned MAX_TRIM = 128;
   localparam int unsigned NOM_TOP  = DIV + MAX_TRIM;
   localparam int unsigned CMP_TOP  = (1 << CMP_W);
   localparam int unsigned CNT_W    = $clog2((NOM_TOP > CMP_TOP) ? NOM_TOP : CMP_TOP) + 1;

   generate
      if (DIV <= MAX_TRIM) begin : g_bad_div
         $error("DIV must exceed the largest trim of %0d pulses", MAX_TRIM);
      end
      if (CMP_W < 2 || CMP_W > 30) begin : g_bad_cmp
         $error("CMP_W out of range");
      end
   endgenerate

   trim_word_t       active;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;
   logic             sec_edge;

   trim_word_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (trim_wr_i),
      .data_i    (trim_data_i),
      .boundary_i(sec_edge),
      .active_o  (active),
      .busy_o    (trim_busy_o)
   );

   trim_limit_calc #(
      .DIV        (DIV),
      .CMP_W      (CMP_W),
      .CNT_W      (CNT_W),
      .BCD_SECONDS(BCD_SECONDS)
   ) u_calc (
      .active_i  (active),
      .sec_i     (sec_bcd_i),
      .cmp_mode_i(cmp_mode_i),
      .cmp_val_i (cmp_val_i),
      .limit_o   (limit)
   );

   presc_counter #(
      .CNT_W    (CNT_W),
      .PULSE_REG(PULSE_REG)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .limit_i(limit),
      .edge_o (sec_edge),
      .pulse_o(sec_pulse_o),
      .cnt_o  (cnt)
   );

endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk #(
   parameter int unsigned DIV   = 32768,
   parameter int unsigned CMP_W = 22,
   parameter int unsigned CNT_W = 24
)(
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             trim_wr_i,
   input logic             cmp_mode_i,
   input logic [CMP_W-1:0] cmp_val_i,
   input logic             sec_edge,
   input logic             trim_busy_o,
   input logic [5:0]       code,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] limit
);

   // R7
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trim_wr_i |=> trim_busy_o);

   // R7
   busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trim_busy_o) |-> $past(sec_edge));

   // R9
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt));

   // R9
   edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_edge && !cmp_mode_i) |=> !sec_edge);

   // R2
   code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 6'd0 && !cmp_mode_i) |-> (limit == CNT_W'(DIV)));

   // R8
   cmp_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_mode_i |-> (limit == CNT_W'(cmp_val_i) + CNT_W'(1)));

endmodule

bind rtc_trim_unit rtc_trim_chk #(
   .DIV  (DIV),
   .CMP_W(CMP_W),
   .CNT_W(CNT_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .trim_wr_i  (trim_wr_i),
   .cmp_mode_i (cmp_mode_i),
   .cmp_val_i  (cmp_val_i),
   .sec_edge   (sec_edge),
   .trim_busy_o(trim_busy_o),
   .code       (active.code),
   .cnt        (cnt),
   .limit      (limit)
);

// File: tb/rtc_trim_unit_tb.sv
module rtc_trim_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 256;
   localparam int CMP_W      = 12;
   localparam int NV         = 15;

   localparam logic [7:0]  V_CFG [NV] = '{8'h00, 8'h01, 8'h05, 8'h3F, 8'h7E,
                                          8'h41, 8'h7F, 8'h05, 8'h05, 8'h05,
                                          8'h85, 8'h85, 8'hC3, 8'hC3, 8'h05};
   localparam logic [7:0]  V_SEC [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                          8'h00, 8'h00, 8'h20, 8'h40, 8'h10,
                                          8'h00, 8'h20, 8'h40, 8'h00, 8'h00};
   localparam logic        V_CMP [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,1};
   localparam int          V_EXP [NV] = '{256, 256, 248, 132, 260,
                                          382, 258, 248, 248, 256,
                                          248, 256, 256, 378, 100};
   localparam string       V_REQ [NV] = '{"R2", "R3", "R3", "R3", "R4",
                                          "R4", "R4", "R5", "R5", "R5",
                                          "R6", "R6", "R6", "R6", "R8"};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick_i = 1'b1;
   logic [7:0]       sec_bcd_i = 8'h00;
   logic             trim_wr_i = 1'b0;
   logic [7:0]       trim_data_i = 8'h00;
   logic             cmp_mode_i = 1'b0;
   logic [CMP_W-1:0] cmp_val_i = CMP_W'(99);
   logic             sec_pulse_o;
   logic             trim_busy_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtc_trim_unit #(.DIV(DIV), .CMP_W(CMP_W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .sec_bcd_i  (sec_bcd_i),
      .trim_wr_i  (trim_wr_i),
      .trim_data_i(trim_data_i),
      .cmp_mode_i (cmp_mode_i),
      .cmp_val_i  (cmp_val_i),
      .sec_pulse_o(sec_pulse_o),
      .trim_busy_o(trim_busy_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_pulse();
      int g = 0;
      do begin @(negedge clk); g++; end while (!sec_pulse_o && g < 5000);
   endtask

   task automatic measure(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!sec_pulse_o && n < 5000);
   endtask

   task automatic write_trim(input logic [7:0] w);
      trim_wr_i   = 1'b1;
      trim_data_i = w;
      @(negedge clk);
      trim_wr_i   = 1'b0;
   endtask

   task automatic wait_busy_clear();
      int g = 0;
      do begin @(negedge clk); g++; end while (trim_busy_o && g < 5000);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pulse", int'(sec_pulse_o), 0);
      check("R1 busy", int'(trim_busy_o), 0);
      rst_n = 1'b1;
      wait_pulse();
      measure(n);
      check("R1 period", n, DIV);

      // R7: write lands mid-second, takes effect after the next strobe
      wait_pulse();
      write_trim(8'h3F);
      check("R7 busy set", int'(trim_busy_o), 1);
      n = 1;
      while (!sec_pulse_o && n < 5000) begin @(negedge clk); n++; end
      check("R7 old second", n, DIV);
      check("R7 busy clear", int'(trim_busy_o), 0);
      measure(n);
      check("R7 new second", n, 132);

      // table walk
      for (int i = 0; i < NV; i++) begin
         sec_bcd_i  = V_SEC[i];
         cmp_mode_i = V_CMP[i];
         write_trim(V_CFG[i]);
         wait_busy_clear();
         measure(n);
         check(V_REQ[i], n, V_EXP[i]);
      end

      // R8: trim word ignored in compare mode even with a large code
      write_trim(8'h3F);
      wait_busy_clear();
      measure(n);
      check("R8 ignore trim", n, 100);

      // R9: tick gap stretches the second, strobe one clock wide
      cmp_mode_i = 1'b0;
      sec_bcd_i  = 8'h00;
      write_trim(8'h00);
      wait_busy_clear();
      tick_i = 1'b0;
      n = 0;
      for (int k = 0; k < 50; k++) begin
         @(negedge clk); n++;
         if (k == 0) check("R9 width", int'(sec_pulse_o), 0);
      end
      tick_i = 1'b1;
      while (!sec_pulse_o && n < 5000) begin @(negedge clk); n++; end
      check("R9 gap", n, DIV + 50);
      @(negedge clk);
      check("R9 width after", int'(sec_pulse_o), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule